// File: doc/BRIEF.md
# Row-Latched Flash Programming Engine

This block models the target side of a nonvolatile program memory while it is being programmed. A host issues single-cycle commands. Each command carries an opcode, a 16-bit data word and an increment flag. A full 16-bit program counter selects the word being worked on. One command loads the counter, and another places data words into a bank of 32 row latches. The low five counter bits pick the latch. When the row is complete, a row-write command programs it into the array row named by the upper counter bits.

The storage is a behavioural array of parameterised depth. Cells read 1 when erased and 0 when programmed. A write can only clear bits, so the stored word becomes the old word AND the latch word. A row must therefore be erased before it is programmed, either alone or with a bulk erase. Erase and write each run for an internally timed, fixed number of cycles, and `busy` is high for that time. Addresses above the implemented depth read as zero and ignore erase and write. The counter saturates at its top value and does not wrap.

Top module: `flash_row_prog`

## Requirements
- R1: After reset, `busy` is 0, `rd_data` is 0, the program counter is 0 and every row latch holds all ones.
- R2: An accepted command with opcode 1 loads all 16 bits of `cmd_data` into the program counter.
- R3: Opcode 2 stores `cmd_data[WORD_W-1:0]` into the latch selected by counter bits [4:0]. When `cmd_inc` is 1, the counter then advances by one.
- R4: When the counter is 16'hFFFF, an increment leaves it at 16'hFFFF. It never wraps to 0.
- R5: Opcode 3 places the word at the counter address on `rd_data` one cycle after acceptance. When `cmd_inc` is 1, the counter then advances by one.
- R6: Opcode 4 sets all 32 words of the row given by counter bits [15:5] to all ones. Other rows keep their contents. `busy` stays high for ERASE_CYC cycles.
- R7: Opcode 5 sets every implemented word to all ones. `busy` stays high for ERASE_CYC cycles.
- R8: Opcode 6 replaces each word of the addressed row with the old word AND its latch. `busy` stays high for WRITE_CYC cycles. The new data is readable in the first cycle after `busy` falls.
- R9: When a row write completes, all latches return to all ones, so a later write leaves words that were not reloaded unchanged.
- R10: Reads at addresses at or above MEM_DEPTH return 0. Erase and write of such rows change no implemented word.
- R11: While `busy` is 1, every command is ignored. The counter, latches, array and `rd_data` are untouched.
- R12: Opcodes 0 and 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe, accepted when `busy` is 0 |
| cmd_op | input | 3 | Opcode |
| cmd_data | input | ADDR_W | Address payload or data word (low WORD_W bits) |
| cmd_inc | input | 1 | Advance the counter after load-data or read |
| busy | output | 1 | Erase or write in progress |
| rd_data | output | WORD_W | Word returned by the last read |

## Verification
Two events can fall in the same cycle. One is the final busy cycle, when the array is updated. The other is a command already waiting on the strobe. The bench provokes this by issuing a row write and then holding a read strobe through the whole busy window. It expects the read to be refused until `busy` falls, and then to return the freshly written word from the unchanged address. A second case offers a load-address, a load-data and a bulk erase during an erase. The bench then checks through later reads and writes that none of them reached the counter, the latches or the array.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_LD_ADDR    = 3'd1,
    OP_LD_DATA    = 3'd2,
    OP_READ       = 3'd3,
    OP_ROW_ERASE  = 3'd4,
    OP_BULK_ERASE = 3'd5,
    OP_ROW_WRITE  = 3'd6,
    OP_RSVD       = 3'd7
  } fp_op_e;

  typedef enum logic [1:0] {
    NV_NONE       = 2'd0,
    NV_ROW_ERASE  = 2'd1,
    NV_BULK_ERASE = 2'd2,
    NV_ROW_WRITE  = 2'd3
  } nv_kind_e;

endpackage

// File: rtl/fp_addr_ctr.sv
module fp_addr_ctr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              step_en,
  output logic [ADDR_W-1:0] pc
);

  localparam logic [ADDR_W-1:0] PC_TOP = '1;

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              pc_en;

  // saturating advance: no wrap past the top address
  always_comb begin
    pc_d  = pc_q;
    pc_en = 1'b0;
    if (ld_en) begin
      pc_d  = ld_val;
      pc_en = 1'b1;
    end else if (step_en && (pc_q != PC_TOP)) begin
      pc_d  = pc_q + 1'b1;
      pc_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  assign pc = pc_q;

endmodule

// File: rtl/fp_row_latch.sv
module fp_row_latch #(
  parameter int WORD_W    = 14,
  parameter int ROW_WORDS = 32,
  localparam int OFS_W    = $clog2(ROW_WORDS)
) (
  input  logic                                clk,
  input  logic                                rst_ni,
  input  logic                                wr_en,
  input  logic [OFS_W-1:0]                    wr_idx,
  input  logic [WORD_W-1:0]                   wr_word,
  input  logic                                fill_en,
  output logic [ROW_WORDS-1:0][WORD_W-1:0]    latch_o
);

  for (genvar i = 0; i < ROW_WORDS; i++) begin : g_word
    logic [WORD_W-1:0] word_q, word_d;
    logic              word_en;

    always_comb begin
      word_d  = word_q;
      word_en = 1'b0;
      if (fill_en) begin
        word_d  = '1;
        word_en = 1'b1;
      end else if (wr_en && (wr_idx == OFS_W'(i))) begin
        word_d  = wr_word;
        word_en = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q <= '1;
      end else if (word_en) begin
        word_q <= word_d;
      end
    end

    assign latch_o[i] = word_q;
  end

endmodule

// File: rtl/fp_nv_seq.sv
module fp_nv_seq
  import flash_prog_pkg::*;
#(
  parameter int ROW_W     = 11,
  parameter int ERASE_CYC = 12,
  parameter int WRITE_CYC = 8,
  localparam int MAX_CYC  = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC,
  localparam int CNT_W    = $clog2(MAX_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             start_en,
  input  nv_kind_e         start_kind,
  input  logic [ROW_W-1:0] start_row,
  output logic             busy,
  output logic             fire,
  output nv_kind_e         fire_kind,
  output logic [ROW_W-1:0] fire_row
);

  typedef enum logic {S_IDLE = 1'b0, S_RUN = 1'b1} seq_st_e;

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  nv_kind_e         kind_q, kind_d;
  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    row_d  = row_q;
    case (st_q)
      S_IDLE: begin
        if (start_en) begin
          st_d   = S_RUN;
          kind_d = start_kind;
          row_d  = start_row;
          cnt_d  = (start_kind == NV_ROW_WRITE) ? CNT_W'(WRITE_CYC - 1)
                                                : CNT_W'(ERASE_CYC - 1);
        end
      end
      S_RUN: begin
        if (cnt_q == '0) begin
          st_d = S_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      kind_q <= NV_NONE;
      row_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      row_q  <= row_d;
    end
  end

  assign busy      = (st_q == S_RUN);
  assign fire      = (st_q == S_RUN) && (cnt_q == '0);
  assign fire_kind = kind_q;
  assign fire_row  = row_q;

endmodule

// File: rtl/fp_nv_array.sv
module fp_nv_array
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WORD_W    = 14,
  parameter int ROW_WORDS = 32,
  parameter int MEM_DEPTH = 256,
  localparam int OFS_W    = $clog2(ROW_WORDS),
  localparam int ROW_W    = ADDR_W - OFS_W,
  localparam int ROWS     = MEM_DEPTH / ROW_WORDS,
  localparam int IDX_W    = $clog2(MEM_DEPTH)
) (
  input  logic                             clk,
  input  logic                             rst_ni,
  input  logic                             op_en,
  input  nv_kind_e                         op_kind,
  input  logic [ROW_W-1:0]                 op_row,
  input  logic [ROW_WORDS-1:0][WORD_W-1:0] latch_i,
  input  logic                             rd_en,
  input  logic [ADDR_W-1:0]                rd_addr,
  output logic [WORD_W-1:0]                rd_data
);

  // nonvolatile cells: no reset
  logic [WORD_W-1:0] mem [MEM_DEPTH];
  logic [ROWS-1:0]   row_sel;
  logic              rd_impl;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] rd_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_rsel
    assign row_sel[r] = (op_row == ROW_W'(r));
  end

  always_ff @(posedge clk) begin
    if (op_en) begin
      for (int r = 0; r < ROWS; r++) begin
        for (int w = 0; w < ROW_WORDS; w++) begin
          case (op_kind)
            NV_BULK_ERASE: mem[r*ROW_WORDS + w] <= '1;
            NV_ROW_ERASE: begin
              if (row_sel[r]) mem[r*ROW_WORDS + w] <= '1;
            end
            NV_ROW_WRITE: begin
              if (row_sel[r]) mem[r*ROW_WORDS + w] <= mem[r*ROW_WORDS + w] & latch_i[w];
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign rd_impl = (rd_addr[ADDR_W-1:IDX_W] == '0);
  assign rd_word = rd_impl ? mem[rd_addr[IDX_W-1:0]] : '0;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_word;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/flash_row_prog.sv
module flash_row_prog
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WORD_W    = 14,
  parameter int ROW_WORDS = 32,
  parameter int MEM_DEPTH = 256,
  parameter int ERASE_CYC = 12,
  parameter int WRITE_CYC = 8,
  localparam int OFS_W    = $clog2(ROW_WORDS),
  localparam int ROW_W    = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_data,
  input  logic              cmd_inc,
  output logic              busy,
  output logic [WORD_W-1:0] rd_data
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_ni = rs_q[1];

  // command decode
  fp_op_e   op;
  logic     acc;
  logic     ld_addr, ld_data, rd_req, step_en;
  logic     start_en;
  nv_kind_e start_kind;

  assign op  = fp_op_e'(cmd_op);
  assign acc = cmd_valid && !busy;

  always_comb begin
    ld_addr    = 1'b0;
    ld_data    = 1'b0;
    rd_req     = 1'b0;
    start_en   = 1'b0;
    start_kind = NV_NONE;
    if (acc) begin
      case (op)
        OP_LD_ADDR:    ld_addr = 1'b1;
        OP_LD_DATA:    ld_data = 1'b1;
        OP_READ:       rd_req  = 1'b1;
        OP_ROW_ERASE:  begin start_en = 1'b1; start_kind = NV_ROW_ERASE;  end
        OP_BULK_ERASE: begin start_en = 1'b1; start_kind = NV_BULK_ERASE; end
        OP_ROW_WRITE:  begin start_en = 1'b1; start_kind = NV_ROW_WRITE;  end
        default: ;
      endcase
    end
  end

  assign step_en = cmd_inc && (ld_data || rd_req);

  logic [ADDR_W-1:0]                pc_q;
  logic [ROW_WORDS-1:0][WORD_W-1:0] latch_w;
  logic                             fire;
  nv_kind_e                         fire_kind;
  logic [ROW_W-1:0]                 fire_row;
  logic                             fill_en;

  assign fill_en = fire && (fire_kind == NV_ROW_WRITE);

  fp_addr_ctr #(.ADDR_W(ADDR_W)) u_pc (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .ld_en   (ld_addr),
    .ld_val  (cmd_data),
    .step_en (step_en),
    .pc      (pc_q)
  );

  fp_row_latch #(.WORD_W(WORD_W), .ROW_WORDS(ROW_WORDS)) u_latch (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .wr_en   (ld_data),
    .wr_idx  (pc_q[OFS_W-1:0]),
    .wr_word (cmd_data[WORD_W-1:0]),
    .fill_en (fill_en),
    .latch_o (latch_w)
  );

  fp_nv_seq #(.ROW_W(ROW_W), .ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)) u_seq (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .start_en   (start_en),
    .start_kind (start_kind),
    .start_row  (pc_q[ADDR_W-1:OFS_W]),
    .busy       (busy),
    .fire       (fire),
    .fire_kind  (fire_kind),
    .fire_row   (fire_row)
  );

  fp_nv_array #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .ROW_WORDS(ROW_WORDS), .MEM_DEPTH(MEM_DEPTH)
  ) u_array (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .op_en   (fire),
    .op_kind (fire_kind),
    .op_row  (fire_row),
    .latch_i (latch_w),
    .rd_en   (rd_req),
    .rd_addr (pc_q),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/flash_row_prog_chk.sv
module flash_row_prog_chk
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WORD_W    = 14,
  parameter int MEM_DEPTH = 256,
  parameter int ERASE_CYC = 12,
  parameter int WRITE_CYC = 8,
  localparam int IDX_W    = $clog2(MEM_DEPTH)
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_data,
  input logic              cmd_inc,
  input logic              busy,
  input logic [WORD_W-1:0] rd_data,
  input logic [ADDR_W-1:0] pc
);

  localparam logic [ADDR_W-1:0] PC_TOP = '1;

  logic acc, stepping;
  assign acc      = cmd_valid && !busy;
  assign stepping = acc && cmd_inc && (cmd_op == OP_LD_DATA || cmd_op == OP_READ);

  // length of the current busy window
  logic [15:0] run_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (busy) begin
      run_q <= run_q + 16'd1;
    end else begin
      run_q <= '0;
    end
  end

  p_ld_addr_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc && cmd_op == OP_LD_ADDR) |=> (pc == $past(cmd_data)));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (stepping && pc != PC_TOP) |=> (pc == $past(pc) + 1'b1));

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (stepping && pc == PC_TOP) |=> (pc == PC_TOP));

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc && (cmd_op == OP_ROW_ERASE || cmd_op == OP_BULK_ERASE || cmd_op == OP_ROW_WRITE))
      |=> busy);

  p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(busy) |-> (run_q == 16'(ERASE_CYC) || run_q == 16'(WRITE_CYC)));

  p_unimpl_zero_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc && cmd_op == OP_READ && pc[ADDR_W-1:IDX_W] != '0) |=> (rd_data == '0));

  p_busy_pc_hold_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |=> $stable(pc));

  p_busy_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |=> $stable(rd_data));

  p_noop_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc && (cmd_op == OP_NOP || cmd_op == OP_RSVD)) |=> ($stable(pc) && !busy));

endmodule

bind flash_row_prog flash_row_prog_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .MEM_DEPTH(MEM_DEPTH),
  .ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)
) u_chk (
  .clk       (clk),
  .rst_ni    (rst_ni),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_data  (cmd_data),
  .cmd_inc   (cmd_inc),
  .busy      (busy),
  .rd_data   (rd_data),
  .pc        (pc_q)
);

// File: tb/flash_row_prog_bench.sv
`timescale 1ns/1ps
module flash_row_prog_bench;

  localparam int ERASE_CYC = 12;
  localparam int WRITE_CYC = 8;

  localparam logic [2:0] NOP = 3'd0, LDA = 3'd1, LDD = 3'd2, RD = 3'd3,
                         RER = 3'd4, BER = 3'd5, RWR = 3'd6, RSV = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [15:0] cmd_data = 16'd0;
  logic        cmd_inc = 1'b0;
  logic        busy;
  logic [13:0] rd_data;

  always #2.5 clk = ~clk;

  flash_row_prog #(.ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)) u_flash_row_prog (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_inc(cmd_inc), .busy(busy), .rd_data(rd_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] d, input logic inc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_inc = inc;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_inc = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // count busy cycles for an operation started by the previous issue
  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] data;
    logic        inc;
    logic        chk;
    logic [13:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VT [NV] = '{
    '{BER, 16'h0000, 1'b0, 1'b0, 14'h0000, 4'd7},
    '{LDA, 16'h0020, 1'b0, 1'b0, 14'h0000, 4'd2},
    '{LDD, 16'h1234, 1'b1, 1'b0, 14'h0000, 4'd3},
    '{LDD, 16'h0ABC, 1'b1, 1'b0, 14'h0000, 4'd3},
    '{LDA, 16'h0020, 1'b0, 1'b0, 14'h0000, 4'd2},
    '{RWR, 16'h0000, 1'b0, 1'b0, 14'h0000, 4'd8},
    '{RD,  16'h0000, 1'b1, 1'b1, 14'h1234, 4'd8},   // R8 programmed word
    '{RD,  16'h0000, 1'b1, 1'b1, 14'h0ABC, 4'd5},   // R5 read with advance
    '{RD,  16'h0000, 1'b1, 1'b1, 14'h3FFF, 4'd9},   // R9 unloaded word kept
    '{LDA, 16'h0020, 1'b0, 1'b0, 14'h0000, 4'd2},
    '{LDD, 16'h3F0F, 1'b0, 1'b0, 14'h0000, 4'd3},
    '{RWR, 16'h0000, 1'b0, 1'b0, 14'h0000, 4'd8},
    '{RD,  16'h0000, 1'b1, 1'b1, 14'h1204, 4'd8},   // R8 AND into stored data
    '{RD,  16'h0000, 1'b0, 1'b1, 14'h0ABC, 4'd9},   // R9 latch refilled with ones
    '{LDA, 16'h001F, 1'b0, 1'b0, 14'h0000, 4'd2},
    '{LDD, 16'h0005, 1'b0, 1'b0, 14'h0000, 4'd3},
    '{RWR, 16'h0000, 1'b0, 1'b0, 14'h0000, 4'd8},
    '{LDA, 16'h0021, 1'b0, 1'b0, 14'h0000, 4'd2},
    '{RER, 16'h0000, 1'b0, 1'b0, 14'h0000, 4'd6},
    '{LDA, 16'h0020, 1'b0, 1'b0, 14'h0000, 4'd2},
    '{RD,  16'h0000, 1'b0, 1'b1, 14'h3FFF, 4'd6},   // R6 row erased
    '{LDA, 16'h001F, 1'b0, 1'b0, 14'h0000, 4'd2},
    '{RD,  16'h0000, 1'b0, 1'b1, 14'h0005, 4'd6},   // R6 neighbour row kept
    '{LDA, 16'h00FF, 1'b0, 1'b0, 14'h0000, 4'd2},
    '{RD,  16'h0000, 1'b0, 1'b1, 14'h3FFF, 4'd7},   // R7 top implemented word
    '{LDA, 16'h0100, 1'b0, 1'b0, 14'h0000, 4'd2},
    '{RD,  16'h0000, 1'b0, 1'b1, 14'h0000, 4'd10},  // R10 unimplemented reads 0
    '{LDD, 16'h0000, 1'b0, 1'b0, 14'h0000, 4'd3},
    '{RWR, 16'h0000, 1'b0, 1'b0, 14'h0000, 4'd10},
    '{LDA, 16'h0000, 1'b0, 1'b0, 14'h0000, 4'd2},
    '{RD,  16'h0000, 1'b0, 1'b1, 14'h3FFF, 4'd10},  // R10 write off the top changes nothing
    '{LDA, 16'hFFFE, 1'b0, 1'b0, 14'h0000, 4'd2},
    '{RD,  16'h0000, 1'b1, 1'b1, 14'h0000, 4'd10},
    '{RD,  16'h0000, 1'b1, 1'b1, 14'h0000, 4'd4},
    '{RD,  16'h0000, 1'b0, 1'b1, 14'h0000, 4'd4},   // R4 still at top, not 0000
    '{LDD, 16'h2222, 1'b1, 1'b0, 14'h0000, 4'd4},
    '{RD,  16'h0000, 1'b0, 1'b1, 14'h0000, 4'd4},
    '{BER, 16'h0000, 1'b0, 1'b0, 14'h0000, 4'd7},
    '{LDA, 16'h001F, 1'b0, 1'b0, 14'h0000, 4'd2},
    '{RD,  16'h0000, 1'b0, 1'b1, 14'h3FFF, 4'd7}    // R7 bulk erase
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    int n;
    do_reset();

    // R1 reset state at the ports
    check("R1 busy", {15'd0, busy}, 16'd0);
    check("R1 rd_data", {2'b0, rd_data}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      issue(VT[i].op, VT[i].data, VT[i].inc);
      wait_idle();
      if (VT[i].chk) check($sformatf("R%0d vec%0d", VT[i].req, i), {2'b0, rd_data}, {2'b0, VT[i].exp});
    end

    // R6/R7/R8 busy window lengths
    issue(LDA, 16'h0040, 1'b0);
    issue(RER, 16'h0000, 1'b0);
    busy_len(n);
    check("R6 erase busy cycles", 16'(n), 16'(ERASE_CYC));
    issue(BER, 16'h0000, 1'b0);
    busy_len(n);
    check("R7 bulk busy cycles", 16'(n), 16'(ERASE_CYC));
    issue(RWR, 16'h0000, 1'b0);
    busy_len(n);
    check("R8 write busy cycles", 16'(n), 16'(WRITE_CYC));

    // R11 commands during busy are dropped
    issue(LDA, 16'h0041, 1'b0);
    issue(LDD, 16'h0007, 1'b0);
    issue(RWR, 16'h0000, 1'b0);
    wait_idle();
    issue(LDA, 16'h0060, 1'b0);
    issue(RER, 16'h0000, 1'b0);
    issue(LDA, 16'h0041, 1'b0);
    issue(LDD, 16'h0000, 1'b0);
    issue(BER, 16'h0000, 1'b0);
    issue(RD,  16'h0000, 1'b1);
    wait_idle();
    check("R11 rd_data held", {2'b0, rd_data}, 16'h3FFF);
    issue(RD, 16'h0000, 1'b0);
    check("R11 pc held", {2'b0, rd_data}, 16'h3FFF);
    issue(LDA, 16'h0041, 1'b0);
    issue(RD, 16'h0000, 1'b0);
    check("R11 bulk dropped", {2'b0, rd_data}, 16'h0007);
    issue(LDA, 16'h0060, 1'b0);
    issue(RWR, 16'h0000, 1'b0);
    wait_idle();
    issue(RD, 16'h0000, 1'b0);
    check("R11 latch untouched", {2'b0, rd_data}, 16'h3FFF);

    // R8 read held through the busy window sees the new row
    issue(LDA, 16'h0043, 1'b0);
    issue(LDD, 16'h0155, 1'b0);
    issue(RWR, 16'h0000, 1'b0);
    cmd_valid = 1'b1; cmd_op = RD; cmd_inc = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R8 read after busy", {2'b0, rd_data}, 16'h0155);

    // R12 reserved opcodes do nothing
    issue(NOP, 16'h0000, 1'b1);
    issue(RSV, 16'h0000, 1'b1);
    check("R12 no busy", {15'd0, busy}, 16'd0);
    issue(RD, 16'h0000, 1'b0);
    check("R12 pc kept", {2'b0, rd_data}, 16'h0155);

    // R1 counter and latches cleared by reset
    issue(LDA, 16'h0000, 1'b0);
    issue(LDD, 16'h0AAA, 1'b0);
    issue(RWR, 16'h0000, 1'b0);
    wait_idle();
    issue(LDA, 16'h0080, 1'b0);
    issue(LDD, 16'h0000, 1'b0);
    do_reset();
    issue(RD, 16'h0000, 1'b0);
    check("R1 pc zero", {2'b0, rd_data}, 16'h0AAA);
    issue(LDA, 16'h0080, 1'b0);
    issue(RWR, 16'h0000, 1'b0);
    wait_idle();
    issue(RD, 16'h0000, 1'b0);
    check("R1 latches ones", {2'b0, rd_data}, 16'h3FFF);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule